// File: doc/BRIEF.md
# Memory Controller Boot-Time Register Stub

This block is a small memory-mapped register bank that stands in for a DRAM controller while firmware boots. Firmware that starts memory initialization or data training, or that kicks off impedance calibration, and then polls for completion, sees every operation already done on its next read. No DRAM timing, PHY behaviour, refresh or memory data path is modelled.

The bus is 32-bit and word-only. A byte offset selects one 32-bit word in a window whose size is a parameter (1 KiB by default). Three registers are implemented: a control register, a calibration control register and a calibration status register. Every other offset reads as zero and is reported through one of two response flags. Read data and both flags are registered, so they appear one clock after the access.

Top module: `memctl_boot_stub`

## Requirements
- R1: After reset, offset 0x000 (control) reads 0x80020000, offset 0x0A8 (calibration control) reads 0x07B00000 and offset 0x0B0 (calibration status) reads 0x80000000.
- R2: A write to the control register always stores bit 31 (start init) as 0, whatever value was written to it.
- R3: A write to the control register always stores bit 30 (start training) as 0, and stores bits 29..0 exactly as written.
- R4: A write to the calibration control register stores the written word and, on the same clock edge, sets bit 31 (calibration done) of the calibration status register. Bits 30..0 of the status register keep their value.
- R5: A write to the calibration status register stores the written word as given, so software can clear the done bit.
- R6: An aligned access to an in-window offset below 0x2E4 that is not one of the three registers reads 0. It raises `unimpl_o` for exactly one cycle, one clock after the access, and does not raise `bus_err_o`. A write there leaves all three registers unchanged.
- R7: An access at an offset of 0x2E4 or above is out of bounds. It reads 0 and raises `bus_err_o` for one cycle, one clock after the access, and does not raise `unimpl_o`. A write there changes no register.
- R8: An access whose offset has bits 1..0 not equal to 00 is rejected. It reads 0, raises `bus_err_o` one clock later, and a write neither stores anything nor sets the calibration done bit.
- R9: `rd_data_o` carries the addressed word in the cycle after `rd_en_i` is sampled high, and is 0 in every other cycle. Both flags are low one clock after any cycle that has no access.
- R10: Driving `rst_ni` low restores all three registers to their reset values and clears `rd_data_o` and both flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (10) | Byte offset within the register window |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe for one cycle |
| rd_data_o | output | 32 | Read data, valid one clock after the read strobe |
| bus_err_o | output | 1 | One-cycle pulse for an out-of-bounds or misaligned access |
| unimpl_o | output | 1 | One-cycle pulse for an access to an unimplemented in-window word |

## Verification
The bench writes words that set both command bits, only one of them, or neither. A design that masked the wrong bit, or cleared more than those two bits, would return a wrong control value. It checks that the done bit is set while the status bits beside it survive, and that a direct status write can clear the done bit again. A design that overwrote the status register, or blocked direct writes, would read back the wrong word. It probes the 0x2E0/0x2E4 boundary and misaligned offsets such as 0x0A9. An off-by-one bound would swap the two flags, and a decoder that ignored the low address bits would set the done bit on a rejected write. Finally it asserts reset between clock edges to show that the outputs clear at once rather than at the next edge.

// File: rtl/memctl_stub_pkg.sv
package memctl_stub_pkg;

  localparam int NREG     = 3;
  localparam int DW       = 32;

  localparam int IDX_CTRL = 0;
  localparam int IDX_CALC = 1;
  localparam int IDX_STAT = 2;

  localparam logic [31:0] OFS_CTRL = 32'h0000_0000;
  localparam logic [31:0] OFS_CALC = 32'h0000_00A8;
  localparam logic [31:0] OFS_STAT = 32'h0000_00B0;

  localparam logic [31:0] RST_CTRL = 32'h8002_0000;
  localparam logic [31:0] RST_CALC = 32'h07B0_0000;
  localparam logic [31:0] RST_STAT = 32'h8000_0000;

  // command bits that complete instantly and therefore never stick
  localparam logic [31:0] CTRL_SELFCLR = 32'hC000_0000;
  // calibration-finished indication in the status word
  localparam logic [31:0] CAL_DONE     = 32'h8000_0000;

  function automatic logic [31:0] reg_offset(input int idx);
    case (idx)
      IDX_CTRL: return OFS_CTRL;
      IDX_CALC: return OFS_CALC;
      default:  return OFS_STAT;
    endcase
  endfunction

  function automatic logic [31:0] reg_reset(input int idx);
    case (idx)
      IDX_CTRL: return RST_CTRL;
      IDX_CALC: return RST_CALC;
      default:  return RST_STAT;
    endcase
  endfunction

endpackage

// File: rtl/memctl_stub_decode.sv
module memctl_stub_decode
  import memctl_stub_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter logic [31:0] OOB_START = 32'h0000_02E4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   hit_o,
  output logic              misal_o,
  output logic              oob_o,
  output logic              unimpl_o
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [31:0]       addr_ext;
  logic              legal;

  assign widx     = addr_i[ADDR_W-1:2];
  assign addr_ext = {{(32-ADDR_W){1'b0}}, addr_i};
  assign misal_o  = |addr_i[1:0];
  assign oob_o    = (addr_ext >= OOB_START);
  assign legal    = ~misal_o & ~oob_o;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    localparam logic [31:0] OFS = reg_offset(g);
    assign hit_o[g] = legal & (widx == OFS[ADDR_W-1:2]);
  end

  assign unimpl_o = legal & ~(|hit_o);

endmodule

// File: rtl/memctl_stub_regs.sv
module memctl_stub_regs
  import memctl_stub_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREG-1:0]          wr_hit_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  q_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] d;
    logic [DW-1:0] q;
    logic          en;

    if (g == IDX_CTRL) begin : g_ctrl
      always_comb begin
        en = wr_hit_i[g];
        d  = wdata_i & ~CTRL_SELFCLR;
      end
    end else if (g == IDX_STAT) begin : g_stat
      always_comb begin
        en = wr_hit_i[g] | wr_hit_i[IDX_CALC];
        if (wr_hit_i[g]) d = wdata_i;
        else             d = q | CAL_DONE;
      end
    end else begin : g_plain
      always_comb begin
        en = wr_hit_i[g];
        d  = wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= reg_reset(g);
      else if (en)  q <= d;
    end

    assign q_o[g] = q;
  end

endmodule

// File: rtl/memctl_stub_rdpath.sv
module memctl_stub_rdpath
  import memctl_stub_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  logic                     acc_i,
  input  logic [NREG-1:0]          hit_i,
  input  logic [NREG-1:0][DW-1:0]  q_i,
  input  logic                     err_i,
  input  logic                     unimpl_i,
  output logic [DW-1:0]            rd_data_o,
  output logic                     bus_err_o,
  output logic                     unimpl_o
);

  logic [DW-1:0] mux;
  logic [DW-1:0] rd_d;
  logic          err_d;
  logic          uni_d;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_i[i]) mux = mux | q_i[i];
    end
    rd_d  = rd_en_i ? mux : '0;
    err_d = acc_i & err_i;
    uni_d = acc_i & unimpl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      bus_err_o <= 1'b0;
      unimpl_o  <= 1'b0;
    end else begin
      rd_data_o <= rd_d;
      bus_err_o <= err_d;
      unimpl_o  <= uni_d;
    end
  end

endmodule

// File: rtl/memctl_boot_stub.sv
module memctl_boot_stub
  import memctl_stub_pkg::*;
#(
  parameter  int          WIN_BYTES = 1024,
  parameter  logic [31:0] OOB_START = 32'h0000_02E4,
  localparam int          ADDR_W    = $clog2(WIN_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  output logic              bus_err_o,
  output logic              unimpl_o
);

  logic [NREG-1:0]         hit;
  logic [NREG-1:0]         wr_hit;
  logic                    misal;
  logic                    oob;
  logic                    unimpl_hit;
  logic                    acc;
  logic [NREG-1:0][DW-1:0] reg_q;
  logic [DW-1:0]           ctrl_q;
  logic [DW-1:0]           calc_q;
  logic [DW-1:0]           stat_q;

  assign acc    = rd_en_i | wr_en_i;
  assign wr_hit = hit & {NREG{wr_en_i}};

  memctl_stub_decode #(
    .ADDR_W    (ADDR_W),
    .OOB_START (OOB_START)
  ) u_decode (
    .addr_i   (addr_i),
    .hit_o    (hit),
    .misal_o  (misal),
    .oob_o    (oob),
    .unimpl_o (unimpl_hit)
  );

  memctl_stub_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wdata_i  (wr_data_i),
    .q_o      (reg_q)
  );

  memctl_stub_rdpath u_rdpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .acc_i     (acc),
    .hit_i     (hit),
    .q_i       (reg_q),
    .err_i     (misal | oob),
    .unimpl_i  (unimpl_hit),
    .rd_data_o (rd_data_o),
    .bus_err_o (bus_err_o),
    .unimpl_o  (unimpl_o)
  );

  assign ctrl_q = reg_q[IDX_CTRL];
  assign calc_q = reg_q[IDX_CALC];
  assign stat_q = reg_q[IDX_STAT];

endmodule

// File: rtl/memctl_boot_stub_chk.sv
module memctl_boot_stub_chk #(
  parameter int          ADDR_W    = 10,
  parameter logic [31:0] OOB_START = 32'h0000_02E4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [31:0]       rd_data_o,
  input logic              bus_err_o,
  input logic              unimpl_o,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       stat_q
);

  logic [31:0] a_ext;
  assign a_ext = {{(32-ADDR_W){1'b0}}, addr_i};

  a_r2_init_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_ext == 32'h0) |=> !ctrl_q[31]);

  a_r3_ctrl_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_ext == 32'h0) |=> (ctrl_q == ($past(wr_data_i) & 32'h3FFF_FFFF)));

  a_r4_cal_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_ext == 32'hA8) |=> (stat_q == ($past(stat_q) | 32'h8000_0000)));

  a_r5_stat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_ext == 32'hB0) |=> (stat_q == $past(wr_data_i)));

  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_err_o && unimpl_o));

  a_r7_oob_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && a_ext >= OOB_START) |=> (rd_data_o == 32'h0 && bus_err_o && !unimpl_o));

  a_r8_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i || wr_en_i) && addr_i[1:0] != 2'b00) |=> bus_err_o);

  a_r8_misal_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1:0] != 2'b00) |=> $stable(stat_q));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i || wr_en_i) |=> (rd_data_o == 32'h0 && !bus_err_o && !unimpl_o));

endmodule

bind memctl_boot_stub memctl_boot_stub_chk #(
  .ADDR_W    (ADDR_W),
  .OOB_START (OOB_START)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .bus_err_o (bus_err_o),
  .unimpl_o  (unimpl_o),
  .ctrl_q    (ctrl_q),
  .stat_q    (stat_q)
);

// File: tb/memctl_boot_stub_test.sv
`timescale 1ns/1ps
module memctl_boot_stub_test;

  logic        clk;
  logic        rst_n;
  logic [9:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        bus_err;
  logic        unimpl;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] rv;
  logic        re, ru;

  memctl_boot_stub uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .bus_err_o (bus_err),
    .unimpl_o  (unimpl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    re = bus_err; ru = unimpl;
    wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rv = rd_data; re = bus_err; ru = unimpl;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic t_reset();
    rd(10'h000); check("R1 ctrl reset", rv, 32'h8002_0000);
    rd(10'h0A8); check("R1 calc reset", rv, 32'h07B0_0000);
    rd(10'h0B0); check("R1 stat reset", rv, 32'h8000_0000);
    check("R9 no flag on good read", {30'b0, re, ru}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(10'h000, 32'hC000_1234); rd(10'h000); check("R2 R3 both cmd bits", rv, 32'h0000_1234);
    wr(10'h000, 32'h8000_0005); rd(10'h000); check("R2 init bit only", rv, 32'h0000_0005);
    wr(10'h000, 32'h40FF_0000); rd(10'h000); check("R3 train bit only", rv, 32'h00FF_0000);
    wr(10'h000, 32'h3FFF_FFFF); rd(10'h000); check("R3 other bits kept", rv, 32'h3FFF_FFFF);
  endtask

  task automatic t_cal();
    wr(10'h0B0, 32'h0); rd(10'h0B0); check("R5 stat cleared", rv, 32'h0);
    wr(10'h0A8, 32'h1234_5678); rd(10'h0A8); check("R4 calc stored", rv, 32'h1234_5678);
    rd(10'h0B0); check("R4 done set", rv, 32'h8000_0000);
    wr(10'h0B0, 32'h0000_0055); rd(10'h0B0); check("R5 stat written", rv, 32'h0000_0055);
    wr(10'h0A8, 32'h0); rd(10'h0B0); check("R4 other stat bits kept", rv, 32'h8000_0055);
    wr(10'h0B0, 32'h7FFF_FFFF); rd(10'h0B0); check("R5 done cleared by write", rv, 32'h7FFF_FFFF);
  endtask

  task automatic t_unimpl();
    rd(10'h004);
    check("R6 unimpl read data", rv, 32'h0);
    check("R6 unimpl flag", {30'b0, re, ru}, 32'h1);
    @(negedge clk);
    check("R6 unimpl one cycle", {31'b0, unimpl}, 32'h0);
    rd(10'h2E0); check("R6 last in-window word", {re, ru, rv[29:0]}, 32'h4000_0000);
    wr(10'h0AC, 32'hFFFF_FFFF); check("R6 unimpl write flag", {30'b0, re, ru}, 32'h1);
    rd(10'h000); check("R6 ctrl untouched", rv, 32'h3FFF_FFFF);
    rd(10'h0A8); check("R6 calc untouched", rv, 32'h0);
    rd(10'h0B0); check("R6 stat untouched", rv, 32'h7FFF_FFFF);
  endtask

  task automatic t_oob();
    rd(10'h2E4);
    check("R7 oob read data", rv, 32'h0);
    check("R7 oob flag", {30'b0, re, ru}, 32'h2);
    @(negedge clk);
    check("R7 oob one cycle", {31'b0, bus_err}, 32'h0);
    rd(10'h3FC); check("R7 top word", {re, ru, rv[29:0]}, 32'h8000_0000);
    wr(10'h2E4, 32'hFFFF_FFFF); check("R7 oob write flag", {30'b0, re, ru}, 32'h2);
    rd(10'h000); check("R7 ctrl untouched", rv, 32'h3FFF_FFFF);
  endtask

  task automatic t_misal();
    rd(10'h002); check("R8 misaligned read", {re, ru, rv[29:0]}, 32'h8000_0000);
    wr(10'h0B0, 32'h0);
    wr(10'h0A9, 32'hFFFF_FFFF); check("R8 misaligned write flag", {30'b0, re, ru}, 32'h2);
    rd(10'h0B0); check("R8 no done bit", rv, 32'h0);
    rd(10'h0A8); check("R8 calc untouched", rv, 32'h0);
    wr(10'h001, 32'hFFFF_FFFF);
    rd(10'h000); check("R8 ctrl untouched", rv, 32'h3FFF_FFFF);
  endtask

  task automatic t_timing();
    @(negedge clk);
    addr = 10'h000; rd_en = 1'b1;
    @(negedge clk);
    check("R9 first of back-to-back", rd_data, 32'h3FFF_FFFF);
    addr = 10'h0A8;
    @(negedge clk);
    check("R9 second of back-to-back", rd_data, 32'h0);
    rd_en = 1'b0; addr = '0;
    @(negedge clk);
    check("R9 idle data zero", rd_data, 32'h0);
  endtask

  task automatic t_async();
    wr(10'h000, 32'h0000_0001);
    wr(10'h0A8, 32'h0000_0002);
    rd(10'h000); check("R10 pre-reset value", rv, 32'h1);
    @(negedge clk);
    addr = 10'h000; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1 rst_n = 1'b0;
    #0.5 check("R10 async clear", rd_data, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    rd(10'h000); check("R10 ctrl restored", rv, 32'h8002_0000);
    rd(10'h0A8); check("R10 calc restored", rv, 32'h07B0_0000);
    rd(10'h0B0); check("R10 stat restored", rv, 32'h8000_0000);
  endtask

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {rd_data[29:0], bus_err, unimpl}, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_cal();
    t_unimpl();
    t_oob();
    t_misal();
    t_timing();
    t_async();
    report();
    $finish;
  end

endmodule